// File: doc/BRIEF.md
# Programmable Down-Counting Counter/Timer

This block is a 16-bit down-counter with two operating modes, chosen by a single mode input. In one-shot counter mode a start command loads the count from a 16-bit preload value. The count then drops by one on every enabled tick. When it passes from 1 to 0, the ready flag is raised and the output pin goes low. The count keeps running and wraps through 0xFFFF until a stop command halts it. While stopped, the current count can be read as two bytes.

In square-wave timer mode a start command sets the output high and begins timing half-periods of the preload length. At the end of each half-period the output toggles and the count is reloaded from the preload registers. Because of this, a preload written mid-way takes effect only at the next half-period boundary. The ready flag is raised once per full period. A stop command does not halt the timer; it only clears the ready flag.

The preload is written one byte at a time through two byte strobes that share a data bus. The start and stop strobes are single-cycle pulses, which a bus decoder produces from reads of dedicated addresses. The tick input is a clock enable taken from whatever clock source the chip selects.

Top module: `ctmr_top`

## Requirements
- R1: After synchronous reset, the ready flag is 0, the output pin is 1, the unit is stopped and both count read bytes are 0.
- R2: The preload is formed from `pl_hi_we`/`pl_lo_we` writes of `pl_wdata` (upper byte bits 15:8, lower byte bits 7:0). In counter mode (`mode_timer`=0) a start while stopped loads the count with the preload. `cnt_hi`/`cnt_lo` return count bits 15:8 and 7:0 from the next cycle on.
- R3: In counter mode, a running count decreases by exactly one in each cycle with `tick`=1 and holds in cycles with `tick`=0.
- R4: In counter mode, the tick that takes the count from 1 to 0 sets `ready` and drives `wave` low in the following cycle. Further ticks wrap the count to 0xFFFF and keep counting down.
- R5: In counter mode, a stop halts the count, which stays readable and unchanged under later ticks. The stop drives `wave` high and clears `ready`. A stop in the same cycle as a start wins, and the unit stays stopped.
- R6: In counter mode, preload writes and start commands issued while running leave the count in progress untouched. A new preload is used only by a start that follows a stop.
- R7: In timer mode (`mode_timer`=1), a start sets `wave` high. `wave` then toggles after every P ticks, where P is the preload, and the count reloads at each toggle.
- R8: In timer mode, `ready` is set when a half-period ends with `wave` low, that is, once per full period, as `wave` returns high.
- R9: In timer mode, a stop does not halt the timer or change `wave`; it only clears `ready`. When a stop and a ready-setting half-period end fall in the same cycle, `ready` ends up 0.
- R10: In timer mode, a preload written during a half-period takes effect only from the next half-period.
- R11: In timer mode, both count read bytes return 0.
- R12: A preload of 0 behaves as 65536 ticks; in counter mode the terminal count arrives on the 65536th tick after start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one count per cycle it is high |
| mode_timer | input | 1 | 1 = square-wave timer mode, 0 = one-shot counter mode |
| pl_wdata | input | 8 | Preload byte write data |
| pl_hi_we | input | 1 | Write strobe for the preload upper byte |
| pl_lo_we | input | 1 | Write strobe for the preload lower byte |
| start_cmd | input | 1 | Start command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| cnt_hi | output | 8 | Current count bits 15:8 (0 in timer mode) |
| cnt_lo | output | 8 | Current count bits 7:0 (0 in timer mode) |
| ready | output | 1 | Terminal-count status flag |
| wave | output | 1 | Output pin: one-shot level or square wave |

## Verification
The assertions take for granted that `mode_timer` changes only while the unit is stopped and in reset. A mode change under a running count is not given a meaning. The stimulus sets the mode right after reset and between scenarios, never while a count is live. Start and stop are taken as pulses that the decoder issues at most once per access. The bench raises each one for a single cycle.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CT_BYTE_W = 8;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TIMER = 1'b1
    } ct_mode_e;

    typedef struct packed {
        logic ready;
        logic wave;
    } ct_flags_t;

    localparam ct_flags_t FLAGS_RESET = '{ready: 1'b0, wave: 1'b1};

endpackage

// File: rtl/ctmr_preload.sv
module ctmr_preload #(
    parameter int BYTE_W = ctmr_pkg::CT_BYTE_W,
    localparam int CW = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              hi_we,
    input  logic              lo_we,
    output logic [CW-1:0]     preload
);
    logic [BYTE_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we) hi_q <= wdata;
            if (lo_we) lo_q <= wdata;
        end
    end

    assign preload = {hi_q, lo_q};

    a_r2_lo_write: assert property (@(posedge clk) disable iff (rst)
        lo_we |=> (preload[BYTE_W-1:0] == $past(wdata)));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CW = 2 * ctmr_pkg::CT_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  ct_mode_e      mode,
    input  logic          start_cmd,
    input  logic          stop_cmd,
    input  logic [CW-1:0] preload,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          go,
    output logic          halt,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_comb begin
        halt   = stop_cmd && (mode == MODE_COUNT);
        go     = start_cmd && !running && !halt;
        expire = running && tick && !halt && (count == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (halt) begin
            running <= 1'b0;
        end else if (go) begin
            count   <= preload;
            running <= 1'b1;
        end else if (running && tick) begin
            if (expire && mode == MODE_TIMER) count <= preload;
            else                              count <= count - ONE;
        end
    end

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (running && tick && !halt && mode == MODE_COUNT)
        |=> (count == $past(count) - ONE));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !start_cmd) |=> $stable(count));

    a_r9_no_halt: assert property (@(posedge clk) disable iff (rst)
        (running && mode == MODE_TIMER) |=> running);
endmodule

// File: rtl/ctmr_flags.sv
module ctmr_flags
    import ctmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ct_mode_e  mode,
    input  logic      stop_cmd,
    input  logic      halt,
    input  logic      go,
    input  logic      expire,
    output ct_flags_t flags
);
    ct_flags_t nxt;

    always_comb begin
        nxt = flags;
        if (halt || go) begin
            nxt.wave = 1'b1;
        end else if (expire) begin
            nxt.wave = (mode == MODE_TIMER) ? !flags.wave : 1'b0;
        end
        if (stop_cmd) begin
            nxt.ready = 1'b0;
        end else if (expire && (mode == MODE_COUNT || !flags.wave)) begin
            nxt.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= FLAGS_RESET;
        else     flags <= nxt;
    end

    a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> !flags.ready);

    a_r5_stop_high: assert property (@(posedge clk) disable iff (rst)
        halt |=> flags.wave);

    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == MODE_TIMER) |=> (flags.wave != $past(flags.wave)));

    a_r8_ready_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ready) |-> $past(expire));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int BYTE_W = ctmr_pkg::CT_BYTE_W,
    localparam int CW = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              mode_timer,
    input  logic [BYTE_W-1:0] pl_wdata,
    input  logic              pl_hi_we,
    input  logic              pl_lo_we,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic              ready,
    output logic              wave
);
    ct_mode_e      mode;
    logic [CW-1:0] preload, count;
    logic          running, go, halt, expire;
    ct_flags_t     flags;

    assign mode = ct_mode_e'(mode_timer);

    ctmr_preload #(.BYTE_W(BYTE_W)) u_preload (
        .clk(clk), .rst(rst), .wdata(pl_wdata),
        .hi_we(pl_hi_we), .lo_we(pl_lo_we), .preload(preload)
    );

    ctmr_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .preload(preload),
        .count(count), .running(running), .go(go), .halt(halt), .expire(expire)
    );

    ctmr_flags u_flags (
        .clk(clk), .rst(rst), .mode(mode), .stop_cmd(stop_cmd),
        .halt(halt), .go(go), .expire(expire), .flags(flags)
    );

    always_comb begin
        if (mode == MODE_TIMER) begin
            cnt_hi = '0;
            cnt_lo = '0;
        end else begin
            cnt_hi = count[CW-1:BYTE_W];
            cnt_lo = count[BYTE_W-1:0];
        end
    end

    assign ready = flags.ready;
    assign wave  = flags.wave;

    a_r4_low_at_zero: assert property (@(posedge clk) disable iff (rst)
        ($fell(wave) && mode == MODE_COUNT) |-> (count == '0));
endmodule

// File: tb/ctmr_top_bench.sv
module ctmr_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       mode_timer = 1'b0;
    logic [7:0] pl_wdata = '0;
    logic       pl_hi_we = 1'b0;
    logic       pl_lo_we = 1'b0;
    logic       start_cmd = 1'b0;
    logic       stop_cmd = 1'b0;
    logic [7:0] cnt_hi, cnt_lo;
    logic       ready, wave;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctmr_top u_ctmr_top (
        .clk(clk), .rst(rst), .tick(tick), .mode_timer(mode_timer),
        .pl_wdata(pl_wdata), .pl_hi_we(pl_hi_we), .pl_lo_we(pl_lo_we),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ready(ready), .wave(wave)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // All drives are set after a falling edge; results are sampled at the next falling edge.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic write_pl(input logic [15:0] v);
        pl_wdata = v[15:8]; pl_hi_we = 1'b1;
        @(negedge clk);
        pl_hi_we = 1'b0;
        pl_wdata = v[7:0]; pl_lo_we = 1'b1;
        @(negedge clk);
        pl_lo_we = 1'b0;
    endtask

    task automatic pulse(input bit do_start, input bit do_stop, input bit with_tick);
        start_cmd = do_start; stop_cmd = do_stop; tick = with_tick;
        @(negedge clk);
        start_cmd = 1'b0; stop_cmd = 1'b0; tick = 1'b0;
    endtask

    function automatic logic [15:0] rd();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        chk("R1 ready", ready, 0);
        chk("R1 wave", wave, 1);
        chk("R1 count", rd(), 16'h0000);
    endtask

    task automatic t_count_basic();
        mode_timer = 1'b0;
        write_pl(16'h0005);
        pulse(1, 0, 0);
        chk("R2 load", rd(), 16'h0005);
        idle(1);
        chk("R3 hold without tick", rd(), 16'h0005);
        ticks(4);
        chk("R3 step", rd(), 16'h0001);
        chk("R4 ready before terminal", ready, 0);
        chk("R4 wave before terminal", wave, 1);
        ticks(1);
        chk("R4 terminal count", rd(), 16'h0000);
        chk("R4 ready", ready, 1);
        chk("R4 wave low", wave, 0);
        ticks(1);
        chk("R4 wrap", rd(), 16'hFFFF);
        pulse(0, 1, 0);
        chk("R5 stop wave high", wave, 1);
        chk("R5 stop ready clear", ready, 0);
        ticks(3);
        chk("R5 held after stop", rd(), 16'hFFFF);
    endtask

    task automatic t_count_reload();
        mode_timer = 1'b0;
        write_pl(16'h0103);
        pulse(1, 0, 0);
        chk("R2 upper byte", rd(), 16'h0103);
        write_pl(16'h0010);
        ticks(1);
        chk("R6 preload write ignored", rd(), 16'h0102);
        pulse(1, 0, 0);
        chk("R6 start while running ignored", rd(), 16'h0102);
        pulse(1, 1, 0);
        ticks(2);
        chk("R5 stop beats start", rd(), 16'h0102);
        pulse(1, 0, 0);
        chk("R6 new preload after stop and start", rd(), 16'h0010);
        pulse(0, 1, 0);
    endtask

    task automatic t_count_zero();
        mode_timer = 1'b0;
        write_pl(16'h0000);
        pulse(1, 0, 0);
        ticks(65535);
        chk("R12 count before terminal", rd(), 16'h0001);
        chk("R12 ready not yet", ready, 0);
        ticks(1);
        chk("R12 ready after 65536", ready, 1);
        chk("R12 wave low", wave, 0);
        pulse(0, 1, 0);
    endtask

    task automatic t_timer();
        mode_timer = 1'b1;
        write_pl(16'h0003);
        pulse(1, 0, 0);
        chk("R11 reads zero", rd(), 16'h0000);
        chk("R7 start high", wave, 1);
        ticks(2);
        chk("R7 mid half-period", wave, 1);
        ticks(1);
        chk("R7 first toggle", wave, 0);
        chk("R8 no ready after half period", ready, 0);
        ticks(3);
        chk("R7 second toggle", wave, 1);
        chk("R8 ready after full period", ready, 1);
        pulse(0, 1, 0);
        chk("R9 stop clears ready", ready, 0);
        chk("R9 stop leaves wave", wave, 1);
        ticks(3);
        chk("R9 still running", wave, 0);
        ticks(1);
        write_pl(16'h0002);
        ticks(2);
        chk("R10 old value completes half-period", wave, 1);
        chk("R8 ready again", ready, 1);
        ticks(1);
        chk("R10 new value not yet", wave, 1);
        ticks(1);
        chk("R10 new half-period of 2", wave, 0);
        ticks(1);
        pulse(0, 1, 1);
        chk("R9 toggle with stop", wave, 1);
        chk("R9 stop wins over set", ready, 0);
        chk("R11 reads zero running", rd(), 16'h0000);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_count_basic();
        t_count_reload();
        t_count_zero();
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        idle(1);
        t_timer();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule